// File: doc/BRIEF.md
# Congestion Notification Rate Controller

This block is the reaction stage on the sending side of a congestion-controlled fabric link. It holds one transmit rate for each destination flow in a table. When a congestion notification packet arrives for a flow, the block halves that flow's rate, but never below a programmable floor. On every round-trip-time tick it walks the whole table and adds one tenth of the line rate to each flow, stopping at the line rate. A flow that was notified since the walk last visited it sits out that one increase.

The pacing stage reads the rate of any flow through a registered lookup port. Flows that have never been touched read as the full line rate. The table has a single update path. A congestion notification takes that path at once, and the round-trip walk, which visits one entry per cycle, waits while it is in use.

Top module: `cnp_rate_ctrl`

## Requirements
- R1: While `rst_n` is low, `query_rate` is 0. After reset, every flow reads as `line_rate`.
- R2: A cycle with `cnp_valid` high sets the rate of flow `cnp_flow` to half its current value, rounded down, unless the floor in R3 applies.
- R3: A halving never leaves a rate below `min_rate`. The result is max(rate/2, `min_rate`).
- R4: Each visit of the round-trip walk to a flow with no pending skip adds floor(`line_rate`/10) to its rate, saturating at `line_rate`.
- R5: A congestion notification marks its flow with a skip. The next walk visit clears the skip and leaves the rate unchanged. A notification that arrives after the walk has passed the flow carries the skip into the following walk.
- R6: When `rtt_tick` and `cnp_valid` arrive in the same cycle for a flow, the flow is halved and gets no increase in that round-trip period.
- R7: After `rtt_tick`, the walk visits flows 0 to NUM_FLOWS-1, one per cycle. It holds its position in every cycle with `cnp_valid` high. An `rtt_tick` that arrives while a walk is running is ignored.
- R8: `query_rate` shows, one clock after a rising edge, the rate of the flow that `query_flow` named at that edge, and never exceeds `line_rate`.
- R9: A congestion notification changes only the rate of the flow it names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnp_valid | input | 1 | Congestion notification strobe, one cycle per notification |
| cnp_flow | input | IDX_W | Flow that the notification names |
| rtt_tick | input | 1 | Start of a round-trip period |
| line_rate | input | RATE_W | Full rate, held constant |
| min_rate | input | RATE_W | Lowest rate a halving may produce |
| query_flow | input | IDX_W | Flow to read |
| query_rate | output | RATE_W | Registered rate of the queried flow |

## Verification
The bench builds the block with 8 flows and a 12-bit rate, with a line rate of 1000 and a floor of 100. At that size every flow can be read back after each step, and one walk takes only eight cycles. This puts within reach the floor after repeated halvings, saturation at full rate, walk stalls under back-to-back notifications, a notification arriving in the same cycle as the tick, a second tick during a running walk, and a notification that arrives after the walk has passed its flow. A table model in the bench works out every expected rate from R2 to R5.

// File: rtl/cnp_rate_pkg.sv
package cnp_rate_pkg;
  // Fraction of line rate added per round-trip period is 1/RAMP_DIVISOR
  localparam int unsigned RAMP_DIVISOR = 10;

  // Which requester owns the single table update path this cycle
  typedef enum logic [1:0] {
    OWN_IDLE  = 2'd0,
    OWN_CNP   = 2'd1,
    OWN_SWEEP = 2'd2
  } port_owner_e;
endpackage

// File: rtl/cnp_sweep_ctrl.sv
module cnp_sweep_ctrl #(
  parameter int unsigned NUM_FLOWS = 512,
  localparam int unsigned IDX_W = $clog2(NUM_FLOWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             stall,
  output logic             busy,
  output logic [IDX_W-1:0] ptr,
  output logic             grant
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_FLOWS - 1);

  logic             busy_q, busy_d;
  logic [IDX_W-1:0] ptr_q, ptr_d;

  always_comb begin
    busy_d = busy_q;
    ptr_d  = ptr_q;
    if (!busy_q) begin
      if (tick) begin
        busy_d = 1'b1;
        ptr_d  = '0;
      end
    end else if (!stall) begin
      if (ptr_q == LAST_IDX) begin
        busy_d = 1'b0;
      end else begin
        ptr_d = ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ptr_q  <= '0;
    end else begin
      busy_q <= busy_d;
      ptr_q  <= ptr_d;
    end
  end

  assign busy  = busy_q;
  assign ptr   = ptr_q;
  assign grant = busy_q & ~stall;
endmodule

// File: rtl/cnp_rate_update.sv
module cnp_rate_update
  import cnp_rate_pkg::*;
#(
  parameter int unsigned RATE_W = 16
) (
  input  port_owner_e       owner,
  input  logic [RATE_W-1:0] cur_rate,
  input  logic              cur_skip,
  input  logic [RATE_W-1:0] line_rate,
  input  logic [RATE_W-1:0] min_rate,
  output logic              wr_en,
  output logic [RATE_W-1:0] new_rate,
  output logic              new_skip
);
  logic [RATE_W-1:0] halved;
  logic [RATE_W-1:0] step;
  logic [RATE_W:0]   raised;

  always_comb begin
    halved = cur_rate >> 1;
    step   = line_rate / RATE_W'(RAMP_DIVISOR);
    raised = {1'b0, cur_rate} + {1'b0, step};
  end

  always_comb begin
    wr_en    = 1'b0;
    new_rate = cur_rate;
    new_skip = cur_skip;
    unique case (owner)
      OWN_CNP: begin
        wr_en    = 1'b1;
        new_rate = (halved < min_rate) ? min_rate : halved;
        new_skip = 1'b1;
      end
      OWN_SWEEP: begin
        wr_en    = 1'b1;
        new_skip = 1'b0;
        if (!cur_skip) begin
          new_rate = (raised > {1'b0, line_rate}) ? line_rate : raised[RATE_W-1:0];
        end
      end
      default: begin
        wr_en = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/cnp_flow_table.sv
module cnp_flow_table #(
  parameter int unsigned NUM_FLOWS = 512,
  parameter int unsigned RATE_W    = 16,
  localparam int unsigned IDX_W = $clog2(NUM_FLOWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] line_rate,
  input  logic [IDX_W-1:0]  upd_idx,
  output logic [RATE_W-1:0] upd_rate,
  output logic              upd_skip,
  input  logic              wr_en,
  input  logic [RATE_W-1:0] wr_rate,
  input  logic              wr_skip,
  input  logic [IDX_W-1:0]  query_idx,
  output logic [RATE_W-1:0] query_rate
);
  logic [RATE_W-1:0]    rate_mem [NUM_FLOWS];
  logic [NUM_FLOWS-1:0] valid_q, valid_d;
  logic [NUM_FLOWS-1:0] skip_q, skip_d;
  logic [RATE_W-1:0]    query_d, query_q;

  // Untouched entries read as full rate, so the rate storage needs no reset
  assign upd_rate = valid_q[upd_idx] ? rate_mem[upd_idx] : line_rate;
  assign upd_skip = skip_q[upd_idx];

  always_comb begin
    valid_d = valid_q;
    skip_d  = skip_q;
    if (wr_en) begin
      valid_d[upd_idx] = 1'b1;
      skip_d[upd_idx]  = wr_skip;
    end
    query_d = valid_q[query_idx] ? rate_mem[query_idx] : line_rate;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      rate_mem[upd_idx] <= wr_rate;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      skip_q  <= '0;
      query_q <= '0;
    end else begin
      valid_q <= valid_d;
      skip_q  <= skip_d;
      query_q <= query_d;
    end
  end

  assign query_rate = query_q;
endmodule

// File: rtl/cnp_rate_ctrl.sv
module cnp_rate_ctrl
  import cnp_rate_pkg::*;
#(
  parameter int unsigned NUM_FLOWS = 512,
  parameter int unsigned RATE_W    = 16,
  localparam int unsigned IDX_W = $clog2(NUM_FLOWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnp_valid,
  input  logic [IDX_W-1:0]  cnp_flow,
  input  logic              rtt_tick,
  input  logic [RATE_W-1:0] line_rate,
  input  logic [RATE_W-1:0] min_rate,
  input  logic [IDX_W-1:0]  query_flow,
  output logic [RATE_W-1:0] query_rate
);
  logic              sweep_busy;
  logic [IDX_W-1:0]  sweep_ptr;
  logic              sweep_grant;
  port_owner_e       owner;
  logic [IDX_W-1:0]  upd_idx;
  logic [RATE_W-1:0] upd_rate;
  logic              upd_skip;
  logic              wr_en;
  logic [RATE_W-1:0] wr_rate;
  logic              wr_skip;

  cnp_sweep_ctrl #(.NUM_FLOWS(NUM_FLOWS)) u_sweep (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (rtt_tick),
    .stall (cnp_valid),
    .busy  (sweep_busy),
    .ptr   (sweep_ptr),
    .grant (sweep_grant)
  );

  // Notifications own the update path; the walk only gets idle cycles
  always_comb begin
    if (cnp_valid) begin
      owner   = OWN_CNP;
      upd_idx = cnp_flow;
    end else if (sweep_grant) begin
      owner   = OWN_SWEEP;
      upd_idx = sweep_ptr;
    end else begin
      owner   = OWN_IDLE;
      upd_idx = sweep_ptr;
    end
  end

  cnp_rate_update #(.RATE_W(RATE_W)) u_update (
    .owner     (owner),
    .cur_rate  (upd_rate),
    .cur_skip  (upd_skip),
    .line_rate (line_rate),
    .min_rate  (min_rate),
    .wr_en     (wr_en),
    .new_rate  (wr_rate),
    .new_skip  (wr_skip)
  );

  cnp_flow_table #(.NUM_FLOWS(NUM_FLOWS), .RATE_W(RATE_W)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_rate  (line_rate),
    .upd_idx    (upd_idx),
    .upd_rate   (upd_rate),
    .upd_skip   (upd_skip),
    .wr_en      (wr_en),
    .wr_rate    (wr_rate),
    .wr_skip    (wr_skip),
    .query_idx  (query_flow),
    .query_rate (query_rate)
  );
endmodule

// File: rtl/cnp_rate_ctrl_chk.sv
module cnp_rate_ctrl_chk #(
  parameter int unsigned NUM_FLOWS = 512,
  parameter int unsigned RATE_W    = 16,
  localparam int unsigned IDX_W = $clog2(NUM_FLOWS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cnp_valid,
  input logic              rtt_tick,
  input logic [RATE_W-1:0] line_rate,
  input logic [RATE_W-1:0] min_rate,
  input logic [RATE_W-1:0] query_rate,
  input logic              sweep_busy,
  input logic [IDX_W-1:0]  sweep_ptr
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_FLOWS - 1);

  // R8
  rate_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    query_rate <= line_rate);

  // R3
  rate_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (query_rate != '0) |-> (query_rate >= min_rate));

  // R7
  sweep_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_busy && cnp_valid) |=> (sweep_busy && sweep_ptr == $past(sweep_ptr)));

  // R7
  sweep_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sweep_busy && rtt_tick) |=> (sweep_busy && sweep_ptr == '0));

  // R7
  sweep_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_busy && !cnp_valid && sweep_ptr != LAST_IDX) |=>
      (sweep_busy && sweep_ptr == $past(sweep_ptr) + 1'b1));

  // R7
  sweep_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_busy && !cnp_valid && sweep_ptr == LAST_IDX) |=> !sweep_busy);
endmodule

bind cnp_rate_ctrl cnp_rate_ctrl_chk #(.NUM_FLOWS(NUM_FLOWS), .RATE_W(RATE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cnp_valid  (cnp_valid),
  .rtt_tick   (rtt_tick),
  .line_rate  (line_rate),
  .min_rate   (min_rate),
  .query_rate (query_rate),
  .sweep_busy (sweep_busy),
  .sweep_ptr  (sweep_ptr)
);

// File: tb/cnp_rate_ctrl_bench.sv
module cnp_rate_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NF   = 8;
  localparam int RW   = 12;
  localparam int IW   = $clog2(NF);
  localparam int LINE = 1000;
  localparam int MINR = 100;
  localparam int STEP = LINE / 10;

  logic          clk;
  logic          rst_n;
  logic          cnp_valid;
  logic [IW-1:0] cnp_flow;
  logic          rtt_tick;
  logic [RW-1:0] line_rate;
  logic [RW-1:0] min_rate;
  logic [IW-1:0] query_flow;
  logic [RW-1:0] query_rate;

  int errors = 0;
  int checks = 0;
  int exp_rate [NF];
  bit exp_skip [NF];

  cnp_rate_ctrl #(.NUM_FLOWS(NF), .RATE_W(RW)) u_cnp_rate_ctrl (
    .clk(clk), .rst_n(rst_n), .cnp_valid(cnp_valid), .cnp_flow(cnp_flow),
    .rtt_tick(rtt_tick), .line_rate(line_rate), .min_rate(min_rate),
    .query_flow(query_flow), .query_rate(query_rate)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    finish_run();
  end

  task automatic check_val(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Model of R2/R3 and R5 marking
  task automatic m_cnp(input int f);
    exp_rate[f] = (exp_rate[f] / 2 < MINR) ? MINR : exp_rate[f] / 2;
    exp_skip[f] = 1'b1;
  endtask

  // Model of one visit of the walk, R4/R5
  task automatic m_visit(input int f);
    if (exp_skip[f]) exp_skip[f] = 1'b0;
    else exp_rate[f] = (exp_rate[f] + STEP > LINE) ? LINE : exp_rate[f] + STEP;
  endtask

  task automatic check_flow(input string req, input int f);
    query_flow = IW'(f);
    @(negedge clk);
    check_val(req, int'(query_rate), exp_rate[f]);
  endtask

  task automatic check_all(input string req);
    for (int f = 0; f < NF; f++) check_flow(req, f);
  endtask

  task automatic send_cnp(input int f);
    cnp_valid = 1'b1;
    cnp_flow  = IW'(f);
    @(negedge clk);
    cnp_valid = 1'b0;
    m_cnp(f);
  endtask

  task automatic full_sweep();
    rtt_tick = 1'b1;
    @(negedge clk);
    rtt_tick = 1'b0;
    repeat (NF + 2) @(negedge clk);
    for (int f = 0; f < NF; f++) m_visit(f);
  endtask

  initial begin
    rst_n = 1'b0; cnp_valid = 1'b0; cnp_flow = '0; rtt_tick = 1'b0;
    line_rate = RW'(LINE); min_rate = RW'(MINR); query_flow = '0;
    for (int f = 0; f < NF; f++) begin exp_rate[f] = LINE; exp_skip[f] = 1'b0; end
    repeat (3) @(negedge clk);
    // R1 reset value of the lookup register
    check_val("R1", int'(query_rate), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // R2 single halving, R9 other flows untouched
    send_cnp(2);
    check_flow("R2", 2);
    check_all("R9");

    // R3 floor after repeated halvings
    send_cnp(2); send_cnp(2); send_cnp(2);
    check_flow("R3", 2);
    send_cnp(2);
    check_flow("R3", 2);

    // R5 pending skip consumed; R4 saturation for full-rate flows
    full_sweep();
    check_flow("R5", 2);
    check_all("R4");
    full_sweep();
    check_flow("R4", 2);
    full_sweep();
    check_all("R4");

    // R6 tick and CNP on flow 0 in one cycle, R7 stall under back-to-back CNPs
    rtt_tick = 1'b1; cnp_valid = 1'b1; cnp_flow = IW'(0);
    @(negedge clk);
    rtt_tick = 1'b0; m_cnp(0);
    cnp_flow = IW'(5);
    @(negedge clk);
    m_cnp(5); cnp_flow = IW'(3);
    @(negedge clk);
    m_cnp(3); cnp_valid = 1'b0;
    repeat (NF + 2) @(negedge clk);
    for (int f = 0; f < NF; f++) m_visit(f);
    check_flow("R6", 0);
    check_all("R7");

    // R7 second tick during a running walk is ignored
    rtt_tick = 1'b1;
    @(negedge clk);
    rtt_tick = 1'b0;
    repeat (2) @(negedge clk);
    rtt_tick = 1'b1;
    @(negedge clk);
    rtt_tick = 1'b0;
    repeat (NF + 2) @(negedge clk);
    for (int f = 0; f < NF; f++) m_visit(f);
    check_all("R7");

    // R5 CNP after the walk passed the flow carries the skip forward
    rtt_tick = 1'b1;
    @(negedge clk);
    rtt_tick = 1'b0;
    repeat (3) @(negedge clk);
    for (int f = 0; f < NF; f++) m_visit(f);
    send_cnp(1);
    repeat (NF + 2) @(negedge clk);
    check_flow("R5", 1);
    full_sweep();
    check_flow("R5", 1);
    full_sweep();
    check_flow("R4", 1);

    // R8 one-cycle lookup latency when switching between unequal flows
    check_flow("R8", 2);
    check_flow("R8", 1);
    check_flow("R8", 7);

    finish_run();
  end
endmodule